// File: doc/BRIEF.md
# Frame-Difference Event Generator

This block turns a stream of fast-readout luma frames into a stream of per-pixel polarity events, like those an event camera produces, but on a frame-synchronous grid. Pixels arrive in raster order, one per clock at most, with a valid strobe and start-of-frame and end-of-line markers. Each luma sample is compared with the sample at the same position in the previous frame, which the block holds in an on-chip reference memory sized for a small configured resolution. Every input pixel yields one output pixel carrying a 2-bit code: no event, brighter, or darker.

The contrast test is the magnitude of the natural log of the current-to-previous luma ratio against a programmable threshold. No logarithm is computed. The block compares two cross-multiplied products with the threshold expressed in 1/1024 units. The threshold register resets to about 20 percent contrast and holds only values between roughly 15 and 30 percent. An enable input is sampled at each frame start. After reset, or after the block is re-enabled, one frame is spent loading the reference before any events can fire.

Top module: `frame_diff_event_gen`

## Requirements
- R1: A pixel gets code 01 (brighter) when cur*1024 > P*(1024+T), where P is the previous luma at that position and T is the active threshold in 1/1024 units.
- R2: A pixel gets code 10 (darker) when cur*(1024+T) < P*1024. Every other compared pixel gets code 00. Code 11 never appears on ev_code.
- R3: A stored previous luma of zero is used as one in both products of R1 and R2.
- R4: The threshold register resets to 205. A write through thr_we/thr_wdata stores the value clamped to the range 154 to 307. The new value applies to pixels that enter after the write cycle.
- R5: The first frame after reset emits code 00 on every pixel and stores its samples as the reference.
- R6: en is sampled on the start-of-frame pixel. A frame that starts with en low emits only 00. The first frame that starts with en high after such a frame also emits only 00. Frames after that compare normally.
- R7: Each valid input pixel produces exactly one output pixel two clock cycles later. ev_sof and ev_eol repeat the input markers of that pixel.
- R8: The pixel position is a column count that restarts on start-of-frame and after end-of-line, plus a row count that restarts on start-of-frame. Each pixel is compared against the same position in the previous frame. This holds even for back-to-back one-pixel frames, where the position is read in the cycle it is being rewritten.
- R9: While reset is held, ev_vld, ev_sof, ev_eol and ev_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Event enable, sampled at frame start |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | THR_W | Threshold value in 1/1024 units |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_luma | input | PIX_W | Unsigned luma sample |
| ev_vld | output | 1 | Output pixel valid |
| ev_sof | output | 1 | Output first pixel of a frame |
| ev_eol | output | 1 | Output last pixel of a line |
| ev_code | output | 2 | Event code: 00 none, 01 brighter, 10 darker |

## Verification
The bench builds the block with 8-bit luma and a 4-column by 2-row reference. That makes a whole frame eight pixels long, so each pixel position can carry its own hand-picked ratio, and every reference entry is rewritten several times within a short run. The small geometry also makes one-pixel frames cheap, which exercises the same-address read-during-write bypass on every pixel. With the 10-bit threshold kept, the clamp limits and the one-step ratio boundaries next to the 20 percent default all fall on exact integer luma pairs.

// File: rtl/fde_pkg.sv
package fde_pkg;

  localparam int FRAC_BITS = 10;

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_ON   = 2'b01,
    EV_OFF  = 2'b10
  } ev_code_e;

endpackage

// File: rtl/fde_thr_reg.sv
module fde_thr_reg #(
  parameter int THR_W   = 10,
  parameter int THR_DEF = 205,
  parameter int THR_MIN = 154,
  parameter int THR_MAX = 307
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [THR_W-1:0] wdata,
  output logic [THR_W-1:0] thr
);

  localparam logic [THR_W-1:0] LO  = THR_W'(THR_MIN);
  localparam logic [THR_W-1:0] HI  = THR_W'(THR_MAX);
  localparam logic [THR_W-1:0] DEF = THR_W'(THR_DEF);

  logic [THR_W-1:0] clamped;

  always_comb begin
    if (wdata < LO)      clamped = LO;
    else if (wdata > HI) clamped = HI;
    else                 clamped = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     thr <= DEF;
    else if (we) thr <= clamped;
  end

  AST_THR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (thr >= LO) && (thr <= HI)); // R4

endmodule

// File: rtl/fde_addr_gen.sv
module fde_addr_gen #(
  parameter int MAX_COLS = 32,
  parameter int MAX_ROWS = 32,
  parameter int AW       = $clog2(MAX_COLS * MAX_ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          sof,
  input  logic          eol,
  output logic [AW-1:0] addr
);

  localparam int CW    = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
  localparam int RW    = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1;
  localparam int DEPTH = MAX_COLS * MAX_ROWS;

  logic [CW-1:0] col_q, col_cur;
  logic [RW-1:0] row_q, row_cur;

  assign col_cur = sof ? '0 : col_q;
  assign row_cur = sof ? '0 : row_q;
  assign addr    = AW'(row_cur) * AW'(MAX_COLS) + AW'(col_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (vld) begin
      if (eol || col_cur == CW'(MAX_COLS - 1)) begin
        col_q <= '0;
        row_q <= (row_cur == RW'(MAX_ROWS - 1)) ? '0 : row_cur + 1'b1;
      end else begin
        col_q <= col_cur + 1'b1;
        row_q <= row_cur;
      end
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    vld |-> (int'(addr) < DEPTH)); // R8

endmodule

// File: rtl/fde_ref_mem.sv
module fde_ref_mem #(
  parameter int DW    = 10,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fde_contrast_cmp.sv
module fde_contrast_cmp
  import fde_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int THR_W = 10
) (
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] prev,
  input  logic [THR_W-1:0] thr,
  output logic             is_on,
  output logic             is_off
);

  localparam int GW = ((THR_W > FRAC_BITS) ? THR_W : FRAC_BITS) + 2;
  localparam int PW = PIX_W + GW;

  logic [PW-1:0] scale, gain, cur_w, prev_w;
  logic [PW-1:0] cur_scaled, cur_gained, prev_scaled, prev_gained;

  always_comb begin
    scale       = PW'(1) << FRAC_BITS;
    gain        = scale + PW'(thr);
    cur_w       = PW'(cur);
    prev_w      = (prev == '0) ? PW'(1) : PW'(prev);
    cur_scaled  = cur_w * scale;
    cur_gained  = cur_w * gain;
    prev_scaled = prev_w * scale;
    prev_gained = prev_w * gain;
    is_on       = cur_scaled > prev_gained;
    is_off      = cur_gained < prev_scaled;
  end

endmodule

// File: rtl/frame_diff_event_gen.sv
module frame_diff_event_gen
  import fde_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int MAX_COLS = 32,
  parameter int MAX_ROWS = 32,
  parameter int THR_W    = 10,
  parameter int THR_DEF  = 205,
  parameter int THR_MIN  = 154,
  parameter int THR_MAX  = 307
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             in_vld,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_luma,
  output logic             ev_vld,
  output logic             ev_sof,
  output logic             ev_eol,
  output logic [1:0]       ev_code
);

  localparam int DEPTH = MAX_COLS * MAX_ROWS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [THR_W-1:0] thr_q;
  logic [AW-1:0]    pix_addr;

  // frame-level compare control
  logic ref_loaded, cmp_run, cmp_now;

  // stage 1 (read issued, data arrives at end of this stage)
  logic             s1_vld, s1_sof, s1_eol, s1_cmp, s1_byp;
  logic [PIX_W-1:0] s1_pix, s1_byp_pix;
  logic [AW-1:0]    s1_addr;
  logic [PIX_W-1:0] ref_rd, prev_eff;
  logic             is_on, is_off;
  ev_code_e         code_nx;

  fde_thr_reg #(
    .THR_W(THR_W), .THR_DEF(THR_DEF), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)
  ) u_thr (
    .clk(clk), .rst(rst), .we(thr_we), .wdata(thr_wdata), .thr(thr_q)
  );

  fde_addr_gen #(
    .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .AW(AW)
  ) u_addr (
    .clk(clk), .rst(rst), .vld(in_vld), .sof(in_sof), .eol(in_eol),
    .addr(pix_addr)
  );

  fde_ref_mem #(
    .DW(PIX_W), .DEPTH(DEPTH), .AW(AW)
  ) u_ref (
    .clk(clk),
    .rd_en(in_vld), .rd_addr(pix_addr), .rd_data(ref_rd),
    .wr_en(s1_vld), .wr_addr(s1_addr), .wr_data(s1_pix)
  );

  assign cmp_now = (in_vld && in_sof) ? (ref_loaded && en) : cmp_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_loaded <= 1'b0;
      cmp_run    <= 1'b0;
    end else if (in_vld && in_sof) begin
      cmp_run    <= ref_loaded && en;
      ref_loaded <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      s1_sof     <= 1'b0;
      s1_eol     <= 1'b0;
      s1_cmp     <= 1'b0;
      s1_byp     <= 1'b0;
      s1_pix     <= '0;
      s1_byp_pix <= '0;
      s1_addr    <= '0;
    end else begin
      s1_vld     <= in_vld;
      s1_sof     <= in_vld && in_sof;
      s1_eol     <= in_vld && in_eol;
      s1_cmp     <= in_vld && cmp_now;
      s1_byp     <= in_vld && s1_vld && (s1_addr == pix_addr);
      s1_byp_pix <= s1_pix;
      if (in_vld) begin
        s1_pix  <= in_luma;
        s1_addr <= pix_addr;
      end
    end
  end

  assign prev_eff = s1_byp ? s1_byp_pix : ref_rd;

  fde_contrast_cmp #(
    .PIX_W(PIX_W), .THR_W(THR_W)
  ) u_cmp (
    .cur(s1_pix), .prev(prev_eff), .thr(thr_q), .is_on(is_on), .is_off(is_off)
  );

  always_comb begin
    code_nx = EV_NONE;
    if (s1_vld && s1_cmp) begin
      if (is_on)       code_nx = EV_ON;
      else if (is_off) code_nx = EV_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_vld  <= 1'b0;
      ev_sof  <= 1'b0;
      ev_eol  <= 1'b0;
      ev_code <= EV_NONE;
    end else begin
      ev_vld  <= s1_vld;
      ev_sof  <= s1_sof;
      ev_eol  <= s1_eol;
      ev_code <= code_nx;
    end
  end

  AST_NO_CODE11: assert property (@(posedge clk) disable iff (rst)
    ev_code != 2'b11); // R2

  AST_ON_OFF_EXCL: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> !(is_on && is_off)); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 ev_vld); // R7

  AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_sof) |=> ##1 ev_sof); // R7

  AST_EOL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_eol) |=> ##1 ev_eol); // R7

endmodule

// File: tb/frame_diff_event_gen_tb.sv
module frame_diff_event_gen_tb;

  localparam int PIX_W = 8;
  localparam int THR_W = 10;
  localparam int NPIX  = 8;

  // {prev, cur, expected code} per pixel of a 4x2 frame, threshold 205
  localparam logic [17:0] VEC [NPIX] = '{
    {8'd100, 8'd100, 2'b00},
    {8'd100, 8'd121, 2'b01},
    {8'd100, 8'd120, 2'b00},
    {8'd100, 8'd83,  2'b10},
    {8'd100, 8'd84,  2'b00},
    {8'd0,   8'd2,   2'b01},
    {8'd0,   8'd1,   2'b00},
    {8'd255, 8'd0,   2'b10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic thr_we = 1'b0;
  logic [THR_W-1:0] thr_wdata = '0;
  logic in_vld = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [PIX_W-1:0] in_luma = '0;
  logic ev_vld, ev_sof, ev_eol;
  logic [1:0] ev_code;

  always #4 clk = ~clk;

  frame_diff_event_gen #(
    .PIX_W(PIX_W), .MAX_COLS(4), .MAX_ROWS(2), .THR_W(THR_W)
  ) u_dut (
    .clk(clk), .rst(rst), .en(en), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .in_vld(in_vld), .in_sof(in_sof), .in_eol(in_eol), .in_luma(in_luma),
    .ev_vld(ev_vld), .ev_sof(ev_sof), .ev_eol(ev_eol), .ev_code(ev_code)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_exp = 0, n_got = 0;
  int exp_cyc [256];
  logic [1:0] exp_code [256];
  logic exp_sof [256], exp_eol [256], exp_dc [256];
  string exp_tag [256];
  int got_cyc [256];
  logic [1:0] got_code [256];
  logic got_sof [256], got_eol [256];

  always @(negedge clk) begin
    if (ev_vld === 1'b1 && n_got < 256) begin
      got_cyc[n_got]  = cyc;
      got_code[n_got] = ev_code;
      got_sof[n_got]  = ev_sof;
      got_eol[n_got]  = ev_eol;
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_exp = 0;
    n_got = 0;
  endtask

  task automatic drive(input logic [7:0] l, input logic s, input logic e,
                       input logic [1:0] code, input bit dc, input string tag);
    @(negedge clk);
    in_vld = 1'b1; in_sof = s; in_eol = e; in_luma = l;
    exp_cyc[n_exp]  = cyc;
    exp_code[n_exp] = code;
    exp_sof[n_exp]  = s;
    exp_eol[n_exp]  = e;
    exp_dc[n_exp]   = dc;
    exp_tag[n_exp]  = tag;
    n_exp++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    end
  endtask

  // uniform 4x2 frame
  task automatic flat_frame(input logic [7:0] l, input logic [1:0] code,
                            input bit dc, input string tag);
    for (int i = 0; i < NPIX; i++)
      drive(l, i == 0, (i % 4) == 3, code, dc, tag);
  endtask

  task automatic verify();
    idle(4);
    chk(n_got == n_exp, "R7 output count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_cyc[i] == exp_cyc[i] + 2, "R7 latency", got_cyc[i], exp_cyc[i] + 2);
      chk(got_sof[i] == exp_sof[i] && got_eol[i] == exp_eol[i], "R7 markers",
          {got_sof[i], got_eol[i]}, {exp_sof[i], exp_eol[i]});
      if (!exp_dc[i])
        chk(got_code[i] == exp_code[i], exp_tag[i], got_code[i], exp_code[i]);
    end
    clear_log();
  endtask

  task automatic load_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_wdata = THR_W'(v);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ev_vld == 1'b0 && ev_sof == 1'b0 && ev_eol == 1'b0, "R9 reset markers",
        {ev_vld, ev_sof, ev_eol}, 0);
    chk(ev_code == 2'b00, "R9 reset code", ev_code, 0);
    @(negedge clk) rst = 1'b0;

    // table walk: reference frame then compared frame
    clear_log();
    for (int i = 0; i < NPIX; i++)
      drive(VEC[i][17:10], i == 0, (i % 4) == 3, 2'b00, 1'b0, "R5 first frame");
    for (int i = 0; i < NPIX; i++)
      drive(VEC[i][9:2], i == 0, (i % 4) == 3, VEC[i][1:0], 1'b0,
            "R1 R2 R3 R8 table");
    verify();

    // threshold clamp below range: 50 -> 154, 112/100 stays quiet
    load_thr(50);
    flat_frame(8'd100, 2'b00, 1'b1, "");
    flat_frame(8'd112, 2'b00, 1'b0, "R4 low clamp");
    verify();
    // above range: 400 -> 307, 131/100 fires ON
    load_thr(400);
    flat_frame(8'd100, 2'b00, 1'b1, "");
    flat_frame(8'd131, 2'b01, 1'b0, "R4 high clamp");
    verify();
    // in range minimum accepted: 154, 116/100 fires ON
    load_thr(154);
    flat_frame(8'd100, 2'b00, 1'b1, "");
    flat_frame(8'd116, 2'b01, 1'b0, "R4 in range");
    verify();

    // enable sampled at frame start
    en = 1'b0;
    flat_frame(8'd100, 2'b00, 1'b0, "R6 disabled frame");
    en = 1'b1;
    flat_frame(8'd200, 2'b00, 1'b0, "R6 reload frame");
    flat_frame(8'd100, 2'b10, 1'b0, "R6 compare resumes");
    verify();

    // back-to-back one-pixel frames hit the same address each cycle
    drive(8'd50,  1'b1, 1'b1, 2'b10, 1'b0, "R8 bypass 1");
    drive(8'd100, 1'b1, 1'b1, 2'b01, 1'b0, "R8 bypass 2");
    drive(8'd50,  1'b1, 1'b1, 2'b10, 1'b0, "R8 bypass 3");
    drive(8'd50,  1'b1, 1'b1, 2'b00, 1'b0, "R8 bypass 4");
    verify();

    // reset restores default threshold and the loading frame
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_log();
    flat_frame(8'd100, 2'b00, 1'b0, "R5 after reset");
    flat_frame(8'd119, 2'b00, 1'b0, "R4 default 205");
    flat_frame(8'd100, 2'b00, 1'b1, "");
    flat_frame(8'd121, 2'b01, 1'b0, "R1 default");
    verify();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule